// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and decides whether an incoming frame is kept or dropped. The decision rests only on the 48-bit destination address at the head of the frame. The address bytes enter one per cycle, qualified by a valid strobe. The first byte carries a start-of-frame marker. While the six bytes stream in, the block captures them and runs an Ethernet CRC-32 over them.

One cycle after the sixth address byte, the block presents its accept/reject verdict together with the class of the destination. A destination falls into one of four classes: the station's own address, the all-ones broadcast address, any other group (multicast) address, or any other individual address. Group addresses are judged through a 64-bin hash table indexed by six bits of the CRC. Individual addresses can optionally be judged through the same table. A promiscuous control accepts everything, and a broadcast-reject control drops all-ones frames.

The configuration inputs carry the contents of the station-address, hash and mode registers. The verdict holds until the next start-of-frame. Checking the FCS over the whole frame and storing the frame are left to other blocks.

Top module: `dst_addr_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `dec_valid` is 0.
- R2: A byte is counted only when `in_valid` is 1. The byte presented with `in_sof` is destination byte 0 (first on the wire). `dec_valid` rises on the cycle after the sixth counted byte and then holds with unchanged `dec_accept` and `dec_kind`. Further bytes of the frame, and idle cycles between bytes, do not disturb the counting or the held verdict.
- R3: A byte with `in_sof` and `in_valid` both set restarts address capture, even if an earlier address is incomplete. `dec_valid` is 0 on the following cycle.
- R4: The station address is assembled as byte 0 = `sta_hi[15:8]`, byte 1 = `sta_hi[7:0]`, byte 2 = `sta_lo[31:24]`, byte 3 = `sta_lo[23:16]`, byte 4 = `sta_lo[15:8]`, byte 5 = `sta_lo[7:0]`. An exact match is always accepted, with `dec_kind` = 1.
- R5: The all-ones destination gets `dec_kind` = 3. It is accepted unless `mode[3]` (broadcast reject) is 1.
- R6: The CRC is the reflected CRC-32: polynomial 0xEDB88320, start value all ones, each byte taken least significant bit first, bytes in wire order, no final inversion. The hash index is bits 31:26 of the result. Index bit 5 selects `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 select the bit within that word.
- R7: A group destination (bit 0 of byte 0 set, not all ones, not the station) gets `dec_kind` = 2 and is accepted exactly when its hash bit is 1.
- R8: Any other destination gets `dec_kind` = 0. It is rejected when `mode[4]` is 0. When `mode[4]` is 1, it is accepted exactly when its hash bit is 1.
- R9: When `mode[5]` (promiscuous) is 1, every frame is accepted. `dec_kind` still reports the class.
- R10: The configuration inputs are sampled in the cycle of the sixth byte. Changing them while a verdict is held does not alter it.
- R11: The broadcast verdict never consults the hash table. An all-ones destination with broadcast reject set is rejected even when every hash bit is 1, unless promiscuous mode is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_sof | input | 1 | Marks the first destination byte (meaningful with `in_valid`) |
| in_byte | input | 8 | Frame byte, wire order |
| sta_lo | input | 32 | Station address bytes 2..5 |
| sta_hi | input | 16 | Station address bytes 0..1 |
| hash_lo | input | 32 | Hash bins 0..31 |
| hash_hi | input | 32 | Hash bins 32..63 |
| mode | input | 32 | Mode word: bit 3 broadcast reject, bit 4 hash for individual addresses, bit 5 promiscuous |
| dec_valid | output | 1 | Verdict available and held |
| dec_accept | output | 1 | 1 = keep frame |
| dec_kind | output | 2 | Destination class: 0 other individual, 1 own station, 2 group, 3 all ones |

## Verification
Two functions can land in one cycle: a held verdict and a fresh start-of-frame. A start-of-frame can also arrive while an address is still half captured, which collides with the completion of the earlier one. The bench provokes both. It starts new frames on the cycle right after a verdict, and it cuts a capture short after three bytes with a new start-of-frame. It also flips configuration while a verdict is held. A behavioural model in the bench tracks the byte count and the expected verdict. The model is compared with `dec_valid`, `dec_accept` and `dec_kind` on every clock, so any cycle in which the verdict drops, rises early or changes value is reported.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int CRC_W      = 32;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_WORD  = 32;
    localparam int STA_HI_W   = 16;
    localparam int MODE_W     = 32;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam int HASH_BINS  = 1 << HASH_IDX_W;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    localparam int MODE_BCAST_REJ_BIT = 3;
    localparam int MODE_HASH_UC_BIT   = 4;
    localparam int MODE_PROMISC_BIT   = 5;

    typedef logic [BYTE_W-1:0] byte_t;
    // element 0 is the first byte seen on the line
    typedef byte_t [ADDR_BYTES-1:0] addr_t;

    typedef struct packed {
        logic promisc;
        logic hash_ucast;
        logic bcast_rej;
    } mode_t;

    typedef enum logic [1:0] {
        DST_OTHER = 2'd0,
        DST_OWN   = 2'd1,
        DST_GROUP = 2'd2,
        DST_ALL   = 2'd3
    } dst_kind_e;

    function automatic mode_t unpack_mode(input logic [MODE_W-1:0] r);
        mode_t m;
        m.promisc    = r[MODE_PROMISC_BIT];
        m.hash_ucast = r[MODE_HASH_UC_BIT];
        m.bcast_rej  = r[MODE_BCAST_REJ_BIT];
        return m;
    endfunction

    // one byte of reflected CRC-32, least significant bit first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input byte_t b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    // station address in wire order from the two register words
    function automatic addr_t station_bytes(input logic [HASH_WORD-1:0] lo,
                                            input logic [STA_HI_W-1:0]  hi);
        addr_t a;
        a[0] = hi[BYTE_W +: BYTE_W];
        a[1] = hi[0 +: BYTE_W];
        for (int k = 2; k < ADDR_BYTES; k++) begin
            a[k] = lo[BYTE_W*(ADDR_BYTES-1-k) +: BYTE_W];
        end
        return a;
    endfunction

endpackage

// File: rtl/dst_filt_capture.sv
module dst_filt_capture
    import dst_filt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_sof,
    input  byte_t in_byte,
    output logic  take,
    output logic  last,
    output addr_t addr_nx
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic             active_q;
    addr_t            addr_q;

    always_comb begin
        pos  = in_sof ? '0 : cnt_q;
        take = in_valid && (in_sof || active_q);
        last = take && (pos == CNT_W'(ADDR_BYTES - 1));
    end

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign addr_nx[g] = (take && (pos == CNT_W'(g))) ? in_byte : addr_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            addr_q   <= '0;
        end else if (take) begin
            cnt_q    <= pos + CNT_W'(1);
            active_q <= !last;
            addr_q   <= addr_nx;
        end
    end

endmodule

// File: rtl/dst_filt_crc.sv
module dst_filt_crc
    import dst_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             in_sof,
    input  byte_t            in_byte,
    output logic [CRC_W-1:0] crc_nx
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    always_comb begin
        crc_base = in_sof ? CRC_SEED : crc_q;
        crc_nx   = take ? crc_step(crc_base, in_byte) : crc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
        end else if (take) begin
            crc_q <= crc_nx;
        end
    end

endmodule

// File: rtl/dst_filt_decide.sv
module dst_filt_decide
    import dst_filt_pkg::*;
(
    input  addr_t                dst,
    input  logic [CRC_W-1:0]     crc,
    input  logic [HASH_WORD-1:0] sta_lo,
    input  logic [STA_HI_W-1:0]  sta_hi,
    input  logic [HASH_WORD-1:0] hash_lo,
    input  logic [HASH_WORD-1:0] hash_hi,
    input  mode_t                mode,
    output logic                 accept,
    output dst_kind_e            kind
);

    logic [HASH_BINS-1:0]  table_bits;
    logic [HASH_IDX_W-1:0] idx;
    logic                  hbit;
    logic                  own;
    logic                  all_ones;
    logic                  group;

    always_comb begin
        table_bits = {hash_hi, hash_lo};
        idx        = crc[CRC_W-1 -: HASH_IDX_W];
        hbit       = table_bits[idx];
        own        = (dst == station_bytes(sta_lo, sta_hi));
        all_ones   = &dst;
        group      = dst[0][0];

        if (own)           kind = DST_OWN;
        else if (all_ones) kind = DST_ALL;
        else if (group)    kind = DST_GROUP;
        else               kind = DST_OTHER;

        unique case (kind)
            DST_OWN:   accept = 1'b1;
            DST_ALL:   accept = !mode.bcast_rej;
            DST_GROUP: accept = hbit;
            default:   accept = mode.hash_ucast && hbit;
        endcase
        if (mode.promisc) accept = 1'b1;
    end

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import dst_filt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [7:0]  in_byte,
    input  logic [31:0] sta_lo,
    input  logic [15:0] sta_hi,
    input  logic [31:0] hash_lo,
    input  logic [31:0] hash_hi,
    input  logic [31:0] mode,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic [1:0]  dec_kind
);

    logic             take;
    logic             last;
    addr_t            addr_nx;
    logic [CRC_W-1:0] crc_nx;
    logic             acc_nx;
    dst_kind_e        kind_nx;
    dst_kind_e        kind_q;

    dst_filt_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_sof  (in_sof),
        .in_byte (in_byte),
        .take    (take),
        .last    (last),
        .addr_nx (addr_nx)
    );

    dst_filt_crc u_crc (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .in_sof (in_sof),
        .in_byte(in_byte),
        .crc_nx (crc_nx)
    );

    dst_filt_decide u_dec (
        .dst    (addr_nx),
        .crc    (crc_nx),
        .sta_lo (sta_lo),
        .sta_hi (sta_hi),
        .hash_lo(hash_lo),
        .hash_hi(hash_hi),
        .mode   (unpack_mode(mode)),
        .accept (acc_nx),
        .kind   (kind_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            kind_q     <= DST_OTHER;
        end else if (last) begin
            dec_valid  <= 1'b1;
            dec_accept <= acc_nx;
            kind_q     <= kind_nx;
        end else if (in_valid && in_sof) begin
            dec_valid  <= 1'b0;
        end
    end

    assign dec_kind = kind_q;

endmodule

// File: rtl/dst_filt_chk.sv
module dst_filt_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_sof,
    input logic [7:0]  in_byte,
    input logic [31:0] sta_lo,
    input logic [15:0] sta_hi,
    input logic [31:0] hash_lo,
    input logic [31:0] hash_hi,
    input logic [31:0] mode,
    input logic        dec_valid,
    input logic        dec_accept,
    input logic [1:0]  dec_kind
);

    logic [2:0] seen;
    logic       ones;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 3'd0;
            ones <= 1'b0;
        end else if (in_valid && in_sof) begin
            seen <= 3'd1;
            ones <= (in_byte == 8'hFF);
        end else if (in_valid && seen != 3'd0 && seen < 3'd6) begin
            seen <= seen + 3'd1;
            ones <= ones && (in_byte == 8'hFF);
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dec_valid);

    p_rise_after_six_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_valid) |-> seen == 3'd6);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !(in_valid && in_sof) |=> dec_valid && $stable(dec_accept) && $stable(dec_kind));

    p_sof_clears_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_sof |=> !dec_valid);

    p_own_accept_r4: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_kind == 2'd1 |-> dec_accept);

    p_bcast_reject_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_valid) && ones && dec_kind == 2'd3 && $past(mode[3]) && !$past(mode[5])
        |-> !dec_accept);

    p_promisc_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_valid) && $past(mode[5]) |-> dec_accept);

endmodule

bind dst_addr_filter dst_filt_chk u_chk (.*);

// File: tb/dst_addr_filter_test.sv
`timescale 1ns/1ps
module dst_addr_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [31:0] sta_lo = 32'h22334455;
    logic [15:0] sta_hi = 16'h0211;
    logic [31:0] hash_lo = '0;
    logic [31:0] hash_hi = '0;
    logic [31:0] mode = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [1:0]  dec_kind;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    dst_addr_filter uut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // serial reference CRC over the 48 destination bits
    function automatic logic [31:0] ref_crc(input logic [47:0] da);
        logic [31:0] c = '1;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 8; j++) begin
                bit fb = c[0] ^ da[47-8*i-7+j];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    function automatic int ref_idx(input logic [47:0] da);
        logic [31:0] c = ref_crc(da);
        return int'(c[31:26]);
    endfunction

    // returns {kind, accept}
    function automatic logic [2:0] ref_decide(input logic [47:0] da);
        int   ix = ref_idx(da);
        bit   hb = (ix >= 32) ? hash_hi[ix-32] : hash_lo[ix];
        logic [1:0] k;
        bit   a;
        if (da == {sta_hi, sta_lo})        begin k = 2'd1; a = 1; end
        else if (da == 48'hFFFFFFFFFFFF)   begin k = 2'd3; a = !mode[3]; end
        else if (da[40])                   begin k = 2'd2; a = hb; end
        else                               begin k = 2'd0; a = mode[4] && hb; end
        if (mode[5]) a = 1;
        return {k, a};
    endfunction

    // behavioural model, updated each rising edge
    logic [7:0] m_b [6];
    int         m_cnt = 0;
    bit         m_active = 0;
    bit         m_vld = 0;
    logic [2:0] m_res = 3'b000;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_active = 0; m_vld = 0; m_res = 3'b000;
        end else if (in_valid) begin
            if (in_sof) begin m_cnt = 0; m_active = 1; m_vld = 0; end
            if (m_active) begin
                m_b[m_cnt] = in_byte;
                m_cnt++;
                if (m_cnt == 6) begin
                    m_active = 0;
                    m_vld = 1;
                    m_res = ref_decide({m_b[0], m_b[1], m_b[2], m_b[3], m_b[4], m_b[5]});
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk({dec_valid, dec_kind, dec_accept} == {m_vld, m_res}, cur_tag,
                "cycle {valid,kind,accept}",
                32'({dec_valid, dec_kind, dec_accept}), 32'({m_vld, m_res}));
        end
    end

    task automatic send_part(input logic [47:0] da, input int n, input int extra, input bit gaps);
        for (int i = 0; i < n + extra; i++) begin
            if (gaps && (i % 2 == 1)) begin
                @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_byte = 8'h3C;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_byte  = (i < 6) ? da[47-8*i -: 8] : 8'(8'hA0 + i);
        end
    endtask

    task automatic send(input logic [47:0] da, input int extra, input bit gaps);
        send_part(da, 6, extra, gaps);
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic expect_dec(input string tag, input bit acc, input logic [1:0] kind);
        chk(dec_valid == 1'b1, tag, "dec_valid", 32'(dec_valid), 32'd1);
        chk(dec_accept == acc, tag, "dec_accept", 32'(dec_accept), 32'(acc));
        chk(dec_kind == kind, tag, "dec_kind", 32'(dec_kind), 32'(kind));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R1", "dec_valid in reset", 32'(dec_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(dec_valid == 1'b0, "R1", "dec_valid after reset", 32'(dec_valid), 32'd0);

        cur_tag = "R4";
        send(48'h021122334455, 0, 0);
        expect_dec("R4", 1, 2'd1);

        cur_tag = "R8";
        send(48'h021122334456, 0, 0);
        expect_dec("R8", 0, 2'd0);

        cur_tag = "R5";
        send(48'hFFFFFFFFFFFF, 0, 0);
        expect_dec("R5", 1, 2'd3);

        cur_tag = "R11";
        mode = 32'h8; hash_lo = '1; hash_hi = '1;
        send(48'hFFFFFFFFFFFF, 0, 0);
        expect_dec("R11", 0, 2'd3);
        hash_lo = '0; hash_hi = '0;

        cur_tag = "R9";
        mode = 32'h28;
        send(48'h0A0B0C0D0E0F, 0, 0);
        expect_dec("R9", 1, 2'd0);
        send(48'hFFFFFFFFFFFF, 0, 0);
        expect_dec("R9", 1, 2'd3);
        mode = 32'h0;

        cur_tag = "R7";
        send(48'h01005E000001, 0, 0);
        expect_dec("R7", 0, 2'd2);
        hash_lo = '1; hash_hi = '1;
        send(48'h01005E000001, 0, 0);
        expect_dec("R7", 1, 2'd2);

        cur_tag = "R6";
        for (int a = 0; a < 8; a++) begin
            logic [47:0] da = 48'h01005E0000A0 + 48'(a * 37);
            int ix = ref_idx(da);
            hash_lo = '0; hash_hi = '0;
            if (ix >= 32) hash_hi[ix-32] = 1'b1; else hash_lo[ix] = 1'b1;
            send(da, 0, 0);
            expect_dec("R6", 1, 2'd2);
            hash_lo = ~hash_lo; hash_hi = ~hash_hi;
            send(da, 0, 0);
            expect_dec("R6", 0, 2'd2);
        end

        cur_tag = "R8";
        begin
            logic [47:0] da = 48'h1C2233445566;
            int ix = ref_idx(da);
            mode = 32'h10; hash_lo = '0; hash_hi = '0;
            if (ix >= 32) hash_hi[ix-32] = 1'b1; else hash_lo[ix] = 1'b1;
            send(da, 0, 0);
            expect_dec("R8", 1, 2'd0);
            hash_lo = '0; hash_hi = '0;
            send(da, 0, 0);
            expect_dec("R8", 0, 2'd0);
            mode = 32'h0;
        end

        cur_tag = "R2";
        send(48'h021122334455, 5, 1);
        expect_dec("R2", 1, 2'd1);
        repeat (3) @(negedge clk);
        expect_dec("R2", 1, 2'd1);

        cur_tag = "R3";
        send_part(48'h021122334455, 3, 0, 0);
        send(48'h021122334499, 0, 0);
        expect_dec("R3", 0, 2'd0);
        send_part(48'h021122334455, 1, 0, 0);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R3", "valid after sof", 32'(dec_valid), 32'd0);
        in_valid = 1'b0; in_sof = 1'b0;
        send(48'h021122334455, 0, 0);
        expect_dec("R3", 1, 2'd1);

        cur_tag = "R10";
        send(48'h021122334456, 0, 0);
        mode = 32'h38; hash_lo = '1; hash_hi = '1; sta_lo = 32'h22334456;
        repeat (4) @(negedge clk);
        expect_dec("R10", 0, 2'd0);

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule